// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Resolver

This block sits between the execute stage of a small 32-bit core and its fetch path. A compare strobe latches five condition flags computed from two operands: equal, signed less, signed greater, unsigned less and unsigned greater. These five flags are held together in one register. A later conditional-branch strobe supplies a 4-bit condition code, the address of the branch and its 10-bit displacement field. One cycle later the block reports whether the branch is taken and the address to fetch next. It also raises an illegal-condition flag when the code names no condition.

The four "or equal" conditions are formed as the union of two stored flags. They are never recomputed from the operands, so they always agree with the single conditions that were latched with them. A branch and a compare presented in the same cycle are resolved against the flags that were in place before that compare.

Top module: `cfb_resolver`

## Requirements
- R1: After reset the flag register is all zero and res_valid, res_taken, res_illegal and res_next_pc are all zero. A branch with code 0 (equal) is then not taken, and one with code 1 (not equal) is taken.
- R2: The equal flag is set by a compare exactly when cmp_a equals cmp_b. The flags change only on a cycle with cmp_en high, and they become visible to branches strobed from the next cycle on.
- R3: One compare updates all four ordering flags together. Signed less and signed greater come from a two's-complement comparison of cmp_a against cmp_b. Unsigned less and unsigned greater come from an unsigned comparison of the same operands.
- R4: Codes 0 to 5 are taken when, in turn: equal; not equal; signed less; signed greater; unsigned less; unsigned greater.
- R5: Codes 6, 7, 8 and 9 are taken when, in turn: signed greater or equal; signed less or equal; unsigned greater or equal; unsigned less or equal.
- R6: A code of 10 to 15 sets res_illegal, leaves res_taken low and gives res_next_pc = br_pc + 2.
- R7: A taken branch gives res_next_pc = br_pc + 2 + 2 × (br_ofs sign-extended from bit 9), modulo 2^32.
- R8: A branch that is not taken gives res_next_pc = br_pc + 2.
- R9: The results are registered. res_valid is high in the cycle after br_en and low otherwise. While res_valid is low, res_taken, res_illegal and res_next_pc are zero.
- R10: When cmp_en and br_en are high in the same cycle, the branch is resolved with the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_en | input | 1 | Conditional-branch strobe |
| br_cond | input | 4 | Condition code |
| br_pc | input | 32 | Address of the branch |
| br_ofs | input | 10 | Signed displacement field, in halfwords |
| res_valid | output | 1 | Branch result present |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Condition code is not defined |
| res_next_pc | output | 32 | Address to fetch next |

## Verification
The assertions assume that br_en, br_cond and br_pc hold known values on every clock after reset, because the checker relates each result to the inputs of the previous cycle. The flag properties take nothing from the operand values: the equal, less and greater flags are mutually exclusive for any pair of operands. The stimulus changes inputs only half a period away from the active edge and never leaves a strobe undriven. It reaches codes 10 to 15 only through deliberate directed cases and a random sweep over the whole 4-bit range.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    // Latched outcome of one compare
    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
        logic ltu;
        logic gtu;
    } cc_flags_t;

    // Condition codes; the numbering is decoded by the instruction set
    localparam int unsigned CC_EQ  = 0;
    localparam int unsigned CC_NE  = 1;
    localparam int unsigned CC_LT  = 2;
    localparam int unsigned CC_GT  = 3;
    localparam int unsigned CC_LTU = 4;
    localparam int unsigned CC_GTU = 5;
    localparam int unsigned CC_GE  = 6;
    localparam int unsigned CC_LE  = 7;
    localparam int unsigned CC_GEU = 8;
    localparam int unsigned CC_LEU = 9;
    localparam int unsigned CC_NUM = 10;

endpackage

// File: rtl/cfb_compare.sv
module cfb_compare
    import cfb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output cc_flags_t       flags
);

    always_comb begin
        flags.eq  = (op_a == op_b);
        flags.lt  = ($signed(op_a) < $signed(op_b));
        flags.gt  = ($signed(op_a) > $signed(op_b));
        flags.ltu = (op_a < op_b);
        flags.gtu = (op_a > op_b);
    end

endmodule

// File: rtl/cfb_cond_eval.sv
module cfb_cond_eval
    import cfb_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic [CW-1:0] cond,
    input  cc_flags_t     flags,
    output logic          hit,
    output logic          bad
);

    localparam int unsigned NCODES = 1 << CW;

    // Per-code decision vector, built by generate over every encodable code
    logic [NCODES-1:0] code_hit;

    for (genvar gi = 0; gi < NCODES; gi++) begin : g_code
        if (gi == CC_EQ) begin : g_eq
            assign code_hit[gi] = flags.eq;
        end else if (gi == CC_NE) begin : g_ne
            assign code_hit[gi] = ~flags.eq;
        end else if (gi == CC_LT) begin : g_lt
            assign code_hit[gi] = flags.lt;
        end else if (gi == CC_GT) begin : g_gt
            assign code_hit[gi] = flags.gt;
        end else if (gi == CC_LTU) begin : g_ltu
            assign code_hit[gi] = flags.ltu;
        end else if (gi == CC_GTU) begin : g_gtu
            assign code_hit[gi] = flags.gtu;
        end else if (gi == CC_GE) begin : g_ge
            assign code_hit[gi] = flags.gt | flags.eq;
        end else if (gi == CC_LE) begin : g_le
            assign code_hit[gi] = flags.lt | flags.eq;
        end else if (gi == CC_GEU) begin : g_geu
            assign code_hit[gi] = flags.gtu | flags.eq;
        end else if (gi == CC_LEU) begin : g_leu
            assign code_hit[gi] = flags.ltu | flags.eq;
        end else begin : g_undef
            assign code_hit[gi] = 1'b0;
        end
    end

    always_comb begin
        bad = (32'(cond) >= CC_NUM);
        hit = code_hit[cond] & ~bad;
    end

endmodule

// File: rtl/cfb_target.sv
module cfb_target #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFS_W = 10
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic             take,
    output logic [XLEN-1:0]  next_pc
);

    localparam int unsigned EXT_W = XLEN - OFS_W - 1;

    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        disp    = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
        seq_pc  = pc + XLEN'(2);
        next_pc = take ? (seq_pc + disp) : seq_pc;
    end

endmodule

// File: rtl/cfb_resolver.sv
module cfb_resolver
    import cfb_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned COND_W = 4,
    parameter int unsigned OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [XLEN-1:0]   cmp_a,
    input  logic [XLEN-1:0]   cmp_b,
    input  logic              br_en,
    input  logic [COND_W-1:0] br_cond,
    input  logic [XLEN-1:0]   br_pc,
    input  logic [OFS_W-1:0]  br_ofs,
    output logic              res_valid,
    output logic              res_taken,
    output logic              res_illegal,
    output logic [XLEN-1:0]   res_next_pc
);

    typedef struct packed {
        cc_flags_t       flags;
        logic            valid;
        logic            taken;
        logic            illegal;
        logic [XLEN-1:0] npc;
    } state_t;

    state_t st_d, st_q;

    cc_flags_t       new_flags;
    logic            cond_hit;
    logic            cond_bad;
    logic [XLEN-1:0] calc_pc;

    cfb_compare #(.XLEN(XLEN)) u_compare (
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .flags (new_flags)
    );

    cfb_cond_eval #(.CW(COND_W)) u_cond (
        .cond  (br_cond),
        .flags (st_q.flags),
        .hit   (cond_hit),
        .bad   (cond_bad)
    );

    cfb_target #(.XLEN(XLEN), .OFS_W(OFS_W)) u_target (
        .pc      (br_pc),
        .ofs     (br_ofs),
        .take    (cond_hit),
        .next_pc (calc_pc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = br_en;
        st_d.taken   = br_en & cond_hit;
        st_d.illegal = br_en & cond_bad;
        st_d.npc     = br_en ? calc_pc : '0;
        if (cmp_en) begin
            st_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Flag register brought out for the bound checker
    cc_flags_t held_flags;
    assign held_flags = st_q.flags;

    assign res_valid   = st_q.valid;
    assign res_taken   = st_q.taken;
    assign res_illegal = st_q.illegal;
    assign res_next_pc = st_q.npc;

endmodule

// File: rtl/cfb_resolver_chk.sv
module cfb_resolver_chk
    import cfb_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned COND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_en,
    input logic              br_en,
    input logic [COND_W-1:0] br_cond,
    input logic [XLEN-1:0]   br_pc,
    input logic              res_valid,
    input logic              res_taken,
    input logic              res_illegal,
    input logic [XLEN-1:0]   res_next_pc,
    input cc_flags_t         flags
);

    AST_SIGNED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.eq, flags.lt, flags.gt})) else $error("signed flags overlap"); // R3

    AST_UNSIGNED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.eq, flags.ltu, flags.gtu})) else $error("unsigned flags overlap"); // R3

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(flags)) else $error("flags moved without compare"); // R2

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_en |=> res_valid) else $error("result missing"); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |=> !res_valid && !res_taken && !res_illegal) else $error("result without strobe"); // R9

    AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && (32'(br_cond) >= CC_NUM)) |=> (res_illegal && !res_taken)) else $error("bad code not flagged"); // R6

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && (32'(br_cond) < CC_NUM)) |=> !res_illegal) else $error("good code flagged"); // R6

    AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && (32'(br_cond) >= CC_NUM)) |=> (res_next_pc == $past(br_pc) + XLEN'(2))) else $error("fall-through address"); // R8

endmodule

bind cfb_resolver cfb_resolver_chk #(.XLEN(XLEN), .COND_W(COND_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_en      (cmp_en),
    .br_en       (br_en),
    .br_cond     (br_cond),
    .br_pc       (br_pc),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_illegal (res_illegal),
    .res_next_pc (res_next_pc),
    .flags       (held_flags)
);

// File: tb/test_cfb_resolver.sv
module test_cfb_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_en = 1'b0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic        br_en = 1'b0;
    logic [3:0]  br_cond = '0;
    logic [31:0] br_pc = '0;
    logic [9:0]  br_ofs = '0;
    logic        res_valid;
    logic        res_taken;
    logic        res_illegal;
    logic [31:0] res_next_pc;

    cfb_resolver i_cfb_resolver (
        .clk(clk), .rst_n(rst_n),
        .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_en(br_en), .br_cond(br_cond), .br_pc(br_pc), .br_ofs(br_ofs),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_illegal(res_illegal), .res_next_pc(res_next_pc)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    bit    m_eq, m_lt, m_gt, m_ltu, m_gtu;
    bit    e_valid, e_taken, e_illegal;
    bit [31:0] e_npc;
    string e_tag = "R1";

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    function automatic bit cond_true(int c);
        case (c)
            0: return m_eq;
            1: return !m_eq;
            2: return m_lt;
            3: return m_gt;
            4: return m_ltu;
            5: return m_gtu;
            6: return m_gt || m_eq;
            7: return m_lt || m_eq;
            8: return m_gtu || m_eq;
            9: return m_ltu || m_eq;
            default: return 0;
        endcase
    endfunction

    // Compare outputs with what the previous cycle's inputs predict
    task automatic check_outputs();
        chk(e_tag, "res_valid",   32'(res_valid),   32'(e_valid));
        chk(e_tag, "res_taken",   32'(res_taken),   32'(e_taken));
        chk(e_tag, "res_illegal", 32'(res_illegal), 32'(e_illegal));
        chk(e_tag, "res_next_pc", res_next_pc,      e_npc);
    endtask

    // One cycle: check at negedge, then drive and update the model
    task automatic step(bit c, logic [31:0] a, logic [31:0] b,
                        bit br, int cond, logic [31:0] pc, int ofs, string tag);
        int s;
        @(negedge clk);
        check_outputs();
        cmp_en = c; cmp_a = a; cmp_b = b;
        br_en = br; br_cond = 4'(cond); br_pc = pc; br_ofs = 10'(ofs);
        e_tag = tag;
        e_valid = br;
        e_illegal = br && (cond >= 10);
        e_taken = br && cond_true(cond);
        s = (ofs >= 512) ? ofs - 1024 : ofs;
        if (br) e_npc = e_taken ? pc + 32'(2 + 2 * s) : pc + 32'd2;
        else    e_npc = '0;
        if (c) begin   // R10: flags update after the branch used old ones
            m_eq  = (a == b);
            m_lt  = ($signed(a) < $signed(b));
            m_gt  = ($signed(a) > $signed(b));
            m_ltu = (a < b);
            m_gtu = (a > b);
        end
    endtask

    task automatic cmp_only(logic [31:0] a, logic [31:0] b, string tag);
        step(1, a, b, 0, 0, 0, 0, tag);
    endtask

    task automatic br_only(int cond, logic [31:0] pc, int ofs, string tag);
        step(0, 0, 0, 1, cond, pc, ofs, tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic all_codes(logic [31:0] pc, string tag);
        for (int k = 0; k < 16; k++) br_only(k, pc + 32'(k * 16), 20, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "reset res_valid",   32'(res_valid),   0);
        chk("R1", "reset res_taken",   32'(res_taken),   0);
        chk("R1", "reset res_illegal", 32'(res_illegal), 0);
        chk("R1", "reset res_next_pc", res_next_pc,      0);
        rst_n = 1'b1;
        e_valid = 0; e_taken = 0; e_illegal = 0; e_npc = 0;
        br_only(0, 32'h100, 8, "R1");     // eq clear: not taken
        br_only(1, 32'h200, 8, "R1");     // ne taken
        idle("R9");
        // R2: equal operands
        cmp_only(32'h1234, 32'h1234, "R2");
        all_codes(32'h1000, "R2");
        // R3: signed and unsigned disagree
        cmp_only(32'hFFFF_FFFF, 32'h1, "R3");
        all_codes(32'h2000, "R4");
        cmp_only(32'h1, 32'h8000_0000, "R3");
        all_codes(32'h3000, "R5");
        cmp_only(32'h5, 32'h9, "R4");
        all_codes(32'h4000, "R5");
        // R2: flags untouched by branches and idle cycles
        idle("R2"); idle("R2");
        br_only(4, 32'h10, 0, "R2");
        // R7: displacement extremes and wrap
        br_only(4, 32'h8000, 511, "R7");
        br_only(4, 32'h8000, 512, "R7");
        br_only(4, 32'h0000_0010, 1023, "R7");
        br_only(4, 32'hFFFF_FFFE, 1, "R7");
        // R8: fall-through wrap
        br_only(5, 32'hFFFF_FFFE, 100, "R8");
        // R6: undefined codes
        br_only(10, 32'h500, 7, "R6");
        br_only(15, 32'h600, 7, "R6");
        // R10: simultaneous compare and branch
        step(1, 32'h7, 32'h7, 1, 0, 32'h700, 3, "R10");
        br_only(0, 32'h704, 3, "R10");
        step(1, 32'h1, 32'h2, 1, 0, 32'h708, 3, "R10");
        br_only(0, 32'h70C, 3, "R10");
        // Random sweep
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            step(1'($urandom_range(0, 1)), ra, rb, 1'($urandom_range(0, 1)),
                 $urandom_range(0, 15), $urandom, $urandom_range(0, 1023), "R4");
        end
        idle("R9");
        idle("R9");
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule